// File: doc/BRIEF.md
# Split-Space Chip-Select Decoder with Output Port Latch

This block turns the upper byte of a 16-bit microcontroller address, together with the active-low program-fetch, read and write strobes, into active-low select lines for the memories and ports on the bus. Instruction fetches go to one of two program memories. Which one is chosen by the top address bit.

Data-space accesses go to one of two data RAMs. The only exception is the highest 256-byte page, which is set aside for I/O. In that page the second RAM is kept off, and the strobes drive an input-port enable and an output-port latch clock instead. The I/O page is decoded only partially: the low address byte is never seen, so every address in the page reaches the same pair of ports.

A small register stores data bit 0 when the output latch clock is released, which is the end of a write to the I/O page. It holds that bit on an indicator output. All select outputs are combinational and active low, so they can connect directly to active-low chip enables.

Top module: `bus_select_decoder`

## Requirements
- R1: `prog0_sel_n` is 0 exactly when `fetch_n` is 0 and `addr_hi[7]` is 0 (program addresses 0000-7FFF). Otherwise it is 1.
- R2: `prog1_sel_n` is 0 exactly when `fetch_n` is 0 and `addr_hi[7]` is 1 (program addresses 8000-FFFF). Otherwise it is 1.
- R3: `ram0_sel_n` is 0 exactly when `addr_hi[7]` is 0, whatever the values of `rd_n` and `wr_n`.
- R4: `ram1_sel_n` is 0 exactly when `addr_hi[7]` is 1 and `addr_hi` is not 8'hFF (data addresses 8000-FEFF). It is therefore always 1 in the I/O page FF00-FFFF.
- R5: `inport_en_n` is 0 exactly when `rd_n` is 0 and `addr_hi` is 8'hFF.
- R6: `outlatch_clk_n` is 0 exactly when `wr_n` is 0 and `addr_hi` is 8'hFF.
- R7: When `rd_n` and `wr_n` are both 1, `inport_en_n` and `outlatch_clk_n` are both 1 for every address.
- R8: At most one of the two program selects is 0 at any time. When `rd_n` and `wr_n` are not both 0, at most one of `ram0_sel_n`, `ram1_sel_n`, `inport_en_n` and `outlatch_clk_n` is 0.
- R9: On the first clock edge that sees `outlatch_clk_n` high after it was low, `indicator` takes the `data0` value that was sampled on the last edge where `outlatch_clk_n` was low. The new value is visible after that edge. Writes outside the I/O page, reads, and changes of `data0` while no write is in progress leave `indicator` unchanged.
- R10: A synchronous active-high `rst` sets `indicator` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the indicator register |
| rst | input | 1 | Synchronous active-high reset |
| addr_hi | input | 8 | Address bits 15..8 |
| fetch_n | input | 1 | Active-low program fetch strobe |
| rd_n | input | 1 | Active-low data read strobe |
| wr_n | input | 1 | Active-low data write strobe |
| data0 | input | 1 | Data bus bit 0 |
| prog0_sel_n | output | 1 | Lower program memory select, active low |
| prog1_sel_n | output | 1 | Upper program memory select, active low |
| ram0_sel_n | output | 1 | Lower data RAM select, active low |
| ram1_sel_n | output | 1 | Upper data RAM select, active low |
| inport_en_n | output | 1 | Input port drive enable, active low |
| outlatch_clk_n | output | 1 | Output port latch clock, active low |
| indicator | output | 1 | Stored output port bit |

## Verification
The exclusivity check on the data-space selects assumes the bus never drives read and write low together. The sweep covers that case for the decode equations but does not apply the exclusivity property to it. The capture property assumes that the latch clock is not held low while reset is applied, and the bench always releases reset with both strobes high. The sweep keeps `data0` at 0, so any I/O-page writes it makes cannot disturb the indicator value that the later latch tests build on.

// File: rtl/bus_dec_pkg.sv
package bus_dec_pkg;

    parameter int ADDR_HI_W  = 8;
    parameter int PROG_BANKS = 2;

    localparam int                BANK_BIT = ADDR_HI_W - 1;
    localparam logic [ADDR_HI_W-1:0] IO_PAGE = {ADDR_HI_W{1'b1}};

    typedef enum logic [1:0] {
        PAGE_LOW  = 2'd0,
        PAGE_HIGH = 2'd1,
        PAGE_IO   = 2'd2
    } page_t;

    typedef struct packed {
        logic [PROG_BANKS-1:0] prog_n;
        logic                  ram0_n;
        logic                  ram1_n;
        logic                  inport_n;
        logic                  outclk_n;
    } sel_bus_t;

    function automatic page_t classify(input logic [ADDR_HI_W-1:0] a);
        if (a == IO_PAGE)
            return PAGE_IO;
        else if (a[BANK_BIT])
            return PAGE_HIGH;
        else
            return PAGE_LOW;
    endfunction

endpackage

// File: rtl/page_classifier.sv
module page_classifier
    import bus_dec_pkg::*;
(
    input  logic [ADDR_HI_W-1:0] addr_hi,
    output page_t                page,
    output logic                 bank_hi
);
    always_comb begin
        page    = classify(addr_hi);
        bank_hi = addr_hi[BANK_BIT];
    end
endmodule

// File: rtl/select_encoder.sv
module select_encoder
    import bus_dec_pkg::*;
(
    input  page_t    page,
    input  logic     bank_hi,
    input  logic     fetch_n,
    input  logic     rd_n,
    input  logic     wr_n,
    output sel_bus_t sel
);
    logic [PROG_BANKS-1:0] prog_n;

    for (genvar b = 0; b < PROG_BANKS; b++) begin : g_prog
        always_comb begin
            prog_n[b] = !(!fetch_n && (int'(bank_hi) == b));
        end
    end

    always_comb begin
        sel.prog_n   = prog_n;
        sel.ram0_n   = (page != PAGE_LOW);
        sel.ram1_n   = (page != PAGE_HIGH);
        sel.inport_n = !((page == PAGE_IO) && !rd_n);
        sel.outclk_n = !((page == PAGE_IO) && !wr_n);
    end
endmodule

// File: rtl/port_latch.sv
module port_latch (
    input  logic clk,
    input  logic rst,
    input  logic latch_clk_n,
    input  logic data0,
    output logic q
);
    logic prev_n;
    logic held;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_n <= 1'b1;
            held   <= 1'b0;
            q      <= 1'b0;
        end else begin
            prev_n <= latch_clk_n;
            if (!latch_clk_n)
                held <= data0;
            if (!prev_n && latch_clk_n)
                q <= held;
        end
    end
endmodule

// File: rtl/bus_select_decoder.sv
module bus_select_decoder
    import bus_dec_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_HI_W-1:0] addr_hi,
    input  logic                 fetch_n,
    input  logic                 rd_n,
    input  logic                 wr_n,
    input  logic                 data0,
    output logic                 prog0_sel_n,
    output logic                 prog1_sel_n,
    output logic                 ram0_sel_n,
    output logic                 ram1_sel_n,
    output logic                 inport_en_n,
    output logic                 outlatch_clk_n,
    output logic                 indicator
);
    page_t    page;
    logic     bank_hi;
    sel_bus_t sel;

    page_classifier u_class (
        .addr_hi (addr_hi),
        .page    (page),
        .bank_hi (bank_hi)
    );

    select_encoder u_enc (
        .page    (page),
        .bank_hi (bank_hi),
        .fetch_n (fetch_n),
        .rd_n    (rd_n),
        .wr_n    (wr_n),
        .sel     (sel)
    );

    port_latch u_latch (
        .clk         (clk),
        .rst         (rst),
        .latch_clk_n (sel.outclk_n),
        .data0       (data0),
        .q           (indicator)
    );

    always_comb begin
        prog0_sel_n    = sel.prog_n[0];
        prog1_sel_n    = sel.prog_n[1];
        ram0_sel_n     = sel.ram0_n;
        ram1_sel_n     = sel.ram1_n;
        inport_en_n    = sel.inport_n;
        outlatch_clk_n = sel.outclk_n;
    end
endmodule

// File: rtl/bus_select_decoder_chk.sv
module bus_select_decoder_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] addr_hi,
    input logic       rd_n,
    input logic       wr_n,
    input logic       data0,
    input logic       prog0_sel_n,
    input logic       prog1_sel_n,
    input logic       ram0_sel_n,
    input logic       ram1_sel_n,
    input logic       inport_en_n,
    input logic       outlatch_clk_n,
    input logic       indicator
);
    // R8
    prog_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({!prog0_sel_n, !prog1_sel_n}));

    // R8
    data_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n) |->
        $onehot0({!ram0_sel_n, !ram1_sel_n, !inport_en_n, !outlatch_clk_n}));

    // R7
    idle_ports_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_n && wr_n) |-> (inport_en_n && outlatch_clk_n));

    // R4
    io_page_ram_off_chk: assert property (@(posedge clk) disable iff (rst)
        (addr_hi == 8'hFF) |-> ram1_sel_n);

    // R9
    capture_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && $rose(outlatch_clk_n)) |=>
        (indicator == $past(data0, 2)));

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$rose(outlatch_clk_n) |=> $stable(indicator));

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> !indicator);
endmodule

bind bus_select_decoder bus_select_decoder_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .addr_hi        (addr_hi),
    .rd_n           (rd_n),
    .wr_n           (wr_n),
    .data0          (data0),
    .prog0_sel_n    (prog0_sel_n),
    .prog1_sel_n    (prog1_sel_n),
    .ram0_sel_n     (ram0_sel_n),
    .ram1_sel_n     (ram1_sel_n),
    .inport_en_n    (inport_en_n),
    .outlatch_clk_n (outlatch_clk_n),
    .indicator      (indicator)
);

// File: tb/bus_select_decoder_bench.sv
module bus_select_decoder_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] addr_hi = 8'h00;
    logic       fetch_n = 1'b1;
    logic       rd_n = 1'b1;
    logic       wr_n = 1'b1;
    logic       data0 = 1'b0;
    logic       prog0_sel_n, prog1_sel_n, ram0_sel_n, ram1_sel_n;
    logic       inport_en_n, outlatch_clk_n, indicator;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic [7:0] a;
        logic [2:0] strobes;
        logic [5:0] exp;
    } item_t;

    item_t sb_q[$];

    always #4 clk = ~clk;

    bus_select_decoder u_bus_select_decoder (
        .clk(clk), .rst(rst), .addr_hi(addr_hi), .fetch_n(fetch_n),
        .rd_n(rd_n), .wr_n(wr_n), .data0(data0),
        .prog0_sel_n(prog0_sel_n), .prog1_sel_n(prog1_sel_n),
        .ram0_sel_n(ram0_sel_n), .ram1_sel_n(ram1_sel_n),
        .inport_en_n(inport_en_n), .outlatch_clk_n(outlatch_clk_n),
        .indicator(indicator)
    );

    task automatic check1(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // driver: apply one address/strobe pattern and push the expected selects
    task automatic drive(input logic [7:0] a, input logic f, input logic r, input logic w);
        item_t it;
        logic io;
        addr_hi = a; fetch_n = f; rd_n = r; wr_n = w;
        io = (a == 8'hFF);
        it.a = a;
        it.strobes = {f, r, w};
        it.exp[5] = !(!f && !a[7]);
        it.exp[4] = !(!f && a[7]);
        it.exp[3] = a[7];
        it.exp[2] = !(a[7] && !io);
        it.exp[1] = !(!r && io);
        it.exp[0] = !(!w && io);
        #1;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
        #1;
    endtask

    // monitor: pop expected items and compare to the live outputs
    initial begin
        forever begin
            item_t it;
            wait (sb_q.size() != 0);
            it = sb_q[0];
            check1("R1 prog0_sel_n", prog0_sel_n, it.exp[5]);
            check1("R2 prog1_sel_n", prog1_sel_n, it.exp[4]);
            check1("R3 ram0_sel_n", ram0_sel_n, it.exp[3]);
            check1("R4 ram1_sel_n", ram1_sel_n, it.exp[2]);
            check1("R5 inport_en_n", inport_en_n, it.exp[1]);
            check1("R6 outlatch_clk_n", outlatch_clk_n, it.exp[0]);
            if (it.strobes[1] && it.strobes[0])
                check1("R7 idle ports", inport_en_n & outlatch_clk_n, 1'b1);
            check1("R8 program exclusive",
                   $countones({!prog0_sel_n, !prog1_sel_n}) <= 1, 1'b1);
            if (it.strobes[1] || it.strobes[0])
                check1("R8 data exclusive",
                       $countones({!ram0_sel_n, !ram1_sel_n, !inport_en_n,
                                   !outlatch_clk_n}) <= 1, 1'b1);
            void'(sb_q.pop_front());
        end
    end

    task automatic io_write(input logic [7:0] a, input logic d);
        @(negedge clk);
        addr_hi = a; data0 = d; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check1("R10 indicator after reset", indicator, 1'b0);
        rst = 1'b0;

        // exhaustive sweep with data0 kept at 0
        for (int a = 0; a < 256; a++) begin
            for (int s = 0; s < 8; s++) begin
                drive(a[7:0], s[2], s[1], s[0]);
            end
        end
        @(negedge clk);
        addr_hi = 8'h00; fetch_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
        @(negedge clk);
        check1("R9 sweep writes of 0 keep indicator", indicator, 1'b0);

        // R9: write 1 into the I/O page (low byte is ignored)
        io_write(8'hFF, 1'b1);
        check1("R9 capture 1", indicator, 1'b1);

        // R9: write outside the window does not change indicator
        io_write(8'h7F, 1'b0);
        check1("R9 write outside window ignored", indicator, 1'b1);
        io_write(8'hFE, 1'b0);
        check1("R9 write to FExx ignored", indicator, 1'b1);

        // R9: read in the window does not change indicator
        @(negedge clk);
        addr_hi = 8'hFF; data0 = 1'b0; rd_n = 1'b0;
        @(negedge clk);
        rd_n = 1'b1;
        @(negedge clk);
        check1("R9 read ignored", indicator, 1'b1);

        // R9: value not taken until the strobe ends
        @(negedge clk);
        addr_hi = 8'hFF; data0 = 1'b0; wr_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check1("R9 no change during write", indicator, 1'b1);
        wr_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check1("R9 capture 0 at end of write", indicator, 1'b0);

        // R9: data0 toggling with no write has no effect
        data0 = 1'b1;
        repeat (3) @(negedge clk);
        check1("R9 idle data ignored", indicator, 1'b0);

        io_write(8'hFF, 1'b1);
        check1("R9 capture 1 again", indicator, 1'b1);

        // R10: synchronous reset clears indicator
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check1("R10 reset clears indicator", indicator, 1'b0);
        rst = 1'b0;
        @(negedge clk);

        done = 1;
        summary();
    end
endmodule